// File: doc/BRIEF.md
# Prime-Field Shift Register with Word Reorganization

This block holds the sixteen-cell state register of a word-oriented stream cipher. Every cell is 31 bits wide, and all arithmetic is done modulo the Mersenne prime 2^31−1. On each step the register moves down by one cell. The top cell takes a new value formed from a weighted sum of five cells. Each weight is a power of two, so each multiplication is a 31-bit rotation, and the additions use an end-around carry. Four 32-bit words are sliced from fixed bit fields of the cells every cycle. These words feed the cipher's nonlinear stage, which lives outside this block.

A one-cycle `start` pulse loads all sixteen cells in parallel. An internal sequencer then runs a fixed number of initialization steps, 32 by default. During these steps the external nonlinear output `w_in`, shifted right by one bit, is also added into the feedback. After that the sequencer makes one work step whose output is thrown away, and then enters streaming. In streaming, `ks_valid` is high and `ks_word` (which is `w_in` XOR the fourth reorganized word) is offered. Each word accepted with `ks_ready` advances the register by one work step.

Top module: `gf31_lfsr`

## Requirements
- R1: After reset, and before any `start`, `busy` and `ks_valid` are 0, all cells are zero, so `x0`..`x3` read 0 and `ks_word` equals `w_in`.
- R2: A `start` pulse loads cell i from `seed_i[31*i+30 : 31*i]`, with cell 0 in the least significant position. The loaded values appear in the reorganized words in the next cycle.
- R3: In a work step the new top cell is S0 + rot8(S0) + rot20(S4) + rot21(S10) + rot17(S13) + rot15(S15), taken modulo 2^31−1, where rotK is a left rotation of the 31-bit cell by K bits.
- R4: Each modular addition keeps the low 31 bits of the 32-bit sum and adds bit 31 back in. A result equal to 2^31−1 is kept and not folded to zero, so a register of all-ones cells with zero injection stays all ones.
- R5: In an initialization step, `w_in[31:1]` is added modulo 2^31−1 on top of the R3 sum.
- R6: On every step, cell i takes the old value of cell i+1 for i from 0 to 14, and cell 15 takes the feedback value.
- R7: The words are formed as follows: `x0` = {S15[30:15], S14[15:0]}, `x1` = {S11[15:0], S9[30:15]}, `x2` = {S7[15:0], S5[30:15]} and `x3` = {S2[15:0], S0[30:15]}.
- R8: After `start`, exactly 32 initialization steps are made, followed by one work step. `busy` is 1 throughout those 33 cycles, and `ks_valid` rises in the cycle after.
- R9: While streaming, the register steps only on a cycle with `ks_ready` high. With `ks_ready` low the words hold and `ks_valid` stays 1.
- R10: `ks_word` always equals `w_in` XOR `x3`.
- R11: A `start` received during initialization or streaming reloads the cells and restarts the sequence from R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the seed and begin initialization |
| seed_i | input | 496 | Sixteen 31-bit initial cell values, cell 0 lowest |
| w_in | input | 32 | Nonlinear stage output for the current cycle |
| ks_ready | input | 1 | Consumer accepts `ks_word` this cycle |
| busy | output | 1 | Initialization or discard step in progress |
| ks_valid | output | 1 | Streaming; `ks_word` is offered |
| ks_word | output | 32 | Keystream word, `w_in` XOR `x3` |
| x0 | output | 32 | Reorganized word 0 |
| x1 | output | 32 | Reorganized word 1 |
| x2 | output | 32 | Reorganized word 2 |
| x3 | output | 32 | Reorganized word 3 |

## Verification
The hardest case to reach is the end-around carry sum that lands exactly on 2^31−1. Random-looking state almost never produces it. The bench reaches it by loading every cell with all ones and holding `w_in` at zero through initialization, so every addition sums to the all-ones value. If that value were folded to zero, the words would collapse within a few steps. Restarts are applied both in the middle of initialization and in the middle of streaming with stalls, and a behavioural model fed by a `w_in` derived from its own words is compared every cycle.

// File: rtl/gf31_pkg.sv
package gf31_pkg;
    localparam int CELL_W     = 31;
    localparam int WORD_W     = 32;
    localparam int NCELL      = 16;
    localparam int INIT_STEPS = 32;
    localparam int HALF_W     = WORD_W / 2;

    // rotation amounts of the feedback terms
    localparam int ROT_A = 8;   // applied to cell 0
    localparam int ROT_B = 20;  // cell 4
    localparam int ROT_C = 21;  // cell 10
    localparam int ROT_D = 17;  // cell 13
    localparam int ROT_E = 15;  // cell 15

    typedef logic [CELL_W-1:0] cell_t;
    typedef cell_t [NCELL-1:0] cells_t;

    typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_DISCARD, PH_STREAM} phase_e;

    function automatic cell_t rotl(input cell_t v, input int k);
        return (v << k) | (v >> (CELL_W - k));
    endfunction

    // addition modulo 2^31-1 with end-around carry
    function automatic cell_t addm(input cell_t a, input cell_t b);
        logic [CELL_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CELL_W-1:0] + {{(CELL_W-1){1'b0}}, s[CELL_W]};
    endfunction
endpackage

// File: rtl/gf31_feedback.sv
module gf31_feedback
    import gf31_pkg::*;
(
    input  cell_t s0,
    input  cell_t s4,
    input  cell_t s10,
    input  cell_t s13,
    input  cell_t s15,
    input  cell_t inj,
    input  logic  init_mode,
    output cell_t fb
);
    cell_t acc;

    always_comb begin
        acc = s0;
        acc = addm(acc, rotl(s0,  ROT_A));
        acc = addm(acc, rotl(s4,  ROT_B));
        acc = addm(acc, rotl(s10, ROT_C));
        acc = addm(acc, rotl(s13, ROT_D));
        acc = addm(acc, rotl(s15, ROT_E));
        if (init_mode) begin
            acc = addm(acc, inj);
        end
        fb = acc;
    end
endmodule

// File: rtl/gf31_seq.sv
module gf31_seq
    import gf31_pkg::*;
#(
    parameter int STEPS = INIT_STEPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ks_ready,
    output logic step,
    output logic init_mode,
    output logic busy,
    output logic ks_valid
);
    localparam int CNT_W = $clog2(STEPS + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        step      = 1'b0;
        init_mode = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: ;
            PH_INIT: begin
                step      = 1'b1;
                init_mode = 1'b1;
                if (seq_q.cnt == CNT_W'(STEPS - 1)) begin
                    seq_d.ph  = PH_DISCARD;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_DISCARD: begin
                step     = 1'b1;
                seq_d.ph = PH_STREAM;
            end
            PH_STREAM: step = ks_ready;
            default: ;
        endcase
        if (start) begin
            seq_d.ph  = PH_INIT;
            seq_d.cnt = '0;
            step      = 1'b0;
            init_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.ph == PH_INIT) || (seq_q.ph == PH_DISCARD);
    assign ks_valid = (seq_q.ph == PH_STREAM);

    AST_INIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_INIT) |-> (int'(seq_q.cnt) < STEPS)); // R8
    AST_VALID_AFTER_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_DISCARD && !start) |=> (ks_valid && !busy)); // R8
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && !ks_ready && !start) |=> ks_valid); // R9
endmodule

// File: rtl/gf31_lfsr.sv
module gf31_lfsr
    import gf31_pkg::*;
#(
    parameter int STEPS = INIT_STEPS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NCELL*CELL_W-1:0] seed_i,
    input  logic [WORD_W-1:0]       w_in,
    input  logic                    ks_ready,
    output logic                    busy,
    output logic                    ks_valid,
    output logic [WORD_W-1:0]       ks_word,
    output logic [WORD_W-1:0]       x0,
    output logic [WORD_W-1:0]       x1,
    output logic [WORD_W-1:0]       x2,
    output logic [WORD_W-1:0]       x3
);
    localparam int TOP = NCELL - 1;

    typedef struct packed {
        cells_t cells;
    } reg_t;

    reg_t  st_d, st_q;
    logic  step, init_mode;
    cell_t fb;

    gf31_seq #(.STEPS(STEPS)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ks_ready  (ks_ready),
        .step      (step),
        .init_mode (init_mode),
        .busy      (busy),
        .ks_valid  (ks_valid)
    );

    gf31_feedback i_fb (
        .s0        (st_q.cells[0]),
        .s4        (st_q.cells[4]),
        .s10       (st_q.cells[10]),
        .s13       (st_q.cells[13]),
        .s15       (st_q.cells[TOP]),
        .inj       (w_in[WORD_W-1:1]),
        .init_mode (init_mode),
        .fb        (fb)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cells = cells_t'(seed_i);
        end else if (step) begin
            for (int i = 0; i < TOP; i++) begin
                st_d.cells[i] = st_q.cells[i+1];
            end
            st_d.cells[TOP] = fb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // word reorganization: high half of a cell or low half of a cell
    assign x0 = {st_q.cells[15][CELL_W-1:CELL_W-HALF_W], st_q.cells[14][HALF_W-1:0]};
    assign x1 = {st_q.cells[11][HALF_W-1:0], st_q.cells[9][CELL_W-1:CELL_W-HALF_W]};
    assign x2 = {st_q.cells[7][HALF_W-1:0],  st_q.cells[5][CELL_W-1:CELL_W-HALF_W]};
    assign x3 = {st_q.cells[2][HALF_W-1:0],  st_q.cells[0][CELL_W-1:CELL_W-HALF_W]};

    assign ks_word = w_in ^ x3;

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (st_q.cells[0] == $past(st_q.cells[1]))); // R6
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !start) |=> $stable(st_q.cells)); // R9
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.cells[TOP] == $past(seed_i[NCELL*CELL_W-1 -: CELL_W]))); // R2
endmodule

// File: tb/test_gf31_lfsr.sv
module test_gf31_lfsr;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 16;
    localparam longint MASK = 64'h7FFF_FFFF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [NC*31-1:0] seed_i = '0;
    logic [31:0]      w_in = '0;
    logic             ks_ready = 1'b0;
    logic             busy, ks_valid;
    logic [31:0]      ks_word, x0, x1, x2, x3;

    gf31_lfsr i_gf31_lfsr (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_i(seed_i), .w_in(w_in),
        .ks_ready(ks_ready), .busy(busy), .ks_valid(ks_valid), .ks_word(ks_word),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     total = 0;
    int     bad = 0;
    int     cyc = 0;
    longint m [NC];
    longint seed_m [NC];
    int     phase = 0;   // 0 idle, 1 init, 2 discard, 3 stream
    int     icnt = 0;
    string  last_tag = "R1";

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic longint rot(longint v, int k);
        return ((v << k) | (v >> (31 - k))) & MASK;
    endfunction

    function automatic longint madd(longint a, longint b);
        longint c;
        c = a + b;
        return (c & MASK) + (c >> 31);
    endfunction

    function automatic longint hi16(longint v);
        return (v >> 15) & 64'hFFFF;
    endfunction

    function automatic longint mx(int k);
        case (k)
            0: return (hi16(m[15]) << 16) | (m[14] & 64'hFFFF);
            1: return ((m[11] & 64'hFFFF) << 16) | hi16(m[9]);
            2: return ((m[7] & 64'hFFFF) << 16) | hi16(m[5]);
            default: return ((m[2] & 64'hFFFF) << 16) | hi16(m[0]);
        endcase
    endfunction

    function automatic longint wfun();
        longint t;
        t = mx(0) ^ (((mx(1) & 64'hFFFF) << 16) | (mx(2) >> 16));
        return (t + 64'h9E37_79B9) & 64'hFFFF_FFFF;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(longint inj, bit init);
        longint f;
        f = m[0];
        f = madd(f, rot(m[0], 8));
        f = madd(f, rot(m[4], 20));
        f = madd(f, rot(m[10], 21));
        f = madd(f, rot(m[13], 17));
        f = madd(f, rot(m[15], 15));
        if (init) f = madd(f, inj);
        for (int i = 0; i < NC - 1; i++) m[i] = m[i+1];
        m[NC-1] = f;
    endtask

    task automatic cycle(bit st, bit rdy, bit zero_w);
        longint w;
        @(negedge clk);
        w = zero_w ? 64'd0 : wfun();
        start = st;
        ks_ready = rdy;
        w_in = w[31:0];
        for (int i = 0; i < NC; i++) seed_i[i*31 +: 31] = seed_m[i][30:0];
        #1;
        check(last_tag, x0, mx(0));
        check(last_tag, x1, mx(1));
        check(last_tag, x2, mx(2));
        check(last_tag, x3, mx(3));
        check("R8 busy", busy, (phase == 1 || phase == 2));
        check("R9 valid", ks_valid, phase == 3);
        check("R10", ks_word, w ^ mx(3));
        if (st) begin
            last_tag = (phase == 0) ? "R2" : "R11";
            for (int i = 0; i < NC; i++) m[i] = seed_m[i];
            phase = 1;
            icnt = 0;
        end else begin
            case (phase)
                1: begin
                    model_step(w >> 1, 1'b1);
                    last_tag = "R5";
                    icnt++;
                    if (icnt == 32) phase = 2;
                end
                2: begin
                    model_step(0, 1'b0);
                    last_tag = "R3";
                    phase = 3;
                end
                3: begin
                    if (rdy) begin
                        model_step(0, 1'b0);
                        last_tag = "R6";
                    end else begin
                        last_tag = "R9";
                    end
                end
                default: last_tag = "R1";
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < NC; i++) seed_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 1'b0);

        // run A: counting seed, full init, streaming with stalls
        for (int i = 0; i < NC; i++) seed_m[i] = (i * 64'h0123_4567 + 64'h55AA_33CC) & MASK;
        cycle(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        // R7: x1 built from cell 11 low half and cell 9 high half
        check("R7", x1, ((seed_m[11] & 64'hFFFF) << 16) | ((seed_m[9] >> 15) & 64'hFFFF));
        for (int i = 0; i < 34; i++) cycle(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) cycle(1'b0, (i % 3) != 0, 1'b0);

        // run B: restart in the middle of initialization
        for (int i = 0; i < NC; i++) seed_m[i] = (64'h7FFF_0000 ^ (i * 64'h0BAD_F00D)) & MASK;
        cycle(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < NC; i++) seed_m[i] = (i % 2 == 0) ? MASK : 64'd0;
        cycle(1'b1, 1'b0, 1'b0);   // R11
        for (int i = 0; i < 40; i++) cycle(1'b0, (i % 4) != 1, 1'b0);

        // restart in the middle of streaming
        for (int i = 0; i < NC; i++) seed_m[i] = (i * 64'h1357_9BDF + 64'h2468_ACE0) & MASK;
        cycle(1'b1, 1'b1, 1'b0);   // R11
        for (int i = 0; i < 45; i++) cycle(1'b0, (i % 2) == 0, 1'b0);

        // run C: all-ones cells, zero injection (R4)
        for (int i = 0; i < NC; i++) seed_m[i] = MASK;
        cycle(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R4 x0", x0, 64'hFFFF_FFFF);
        check("R4 x3", x3, 64'hFFFF_FFFF);
        check("R4 valid", ks_valid, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule